// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences each memory access of a 16-bit microcontroller core. It accepts one request at a time and sorts it into one of three kinds. An internal access goes to the special-function, RAM or on-chip ROM ranges. An external access goes out on the bus pins. A blocked access targets an address the current processor mode cannot reach.

For an external access the block first pulses the address latch enable for one half-phase. It then holds the read or write strobe low for a stretch of 2, 3 or 4 half-phases, which correspond to the no-wait, 1.5x and 2x access lengths. Internal accesses skip the address phase and always run at the no-wait length. When an access ends, the block reports completion to the core with a one-cycle pulse.

The core presents requests on a valid/ready pair. `req_ready` is high only while the block is idle, so the core must hold `req_valid` and its request fields until a clock edge sees both signals high. No second request is taken until the previous one has completed. One clock cycle of `clk` is one half-phase of the internal bus clock. The shared read-enable pin carries a free-running phase signal in single-chip mode, and carries the read-enable strobe in the bus modes.

Top module: `ebw_ctrl`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From that edge until the first idle cycle after its completion pulse, `req_ready` stays 0.
- R2: With `cfg_wait_n`=1, an external access holds its strobe low for exactly 2 cycles.
- R3: With `cfg_wait_n`=0 and `cfg_wait_sel`=1, an external access holds its strobe low for exactly 3 cycles.
- R4: With `cfg_wait_n`=0 and `cfg_wait_sel`=0, an external access holds its strobe low for exactly 4 cycles.
- R5: Every external access raises `bus_ale` for exactly the first cycle after acceptance, and the strobe follows directly after it. Internal and blocked accesses never raise `bus_ale`, and `bus_ale` is never high while a write strobe is low.
- R6: Accesses are internal when the address is below 0x1000. In mode 01 only, addresses 0x8000 through 0x1FFFF are also internal. Internal accesses hold the strobe phase for 2 cycles starting the cycle after acceptance, whatever the wait bits say.
- R7: A read (`req_write`=0) drives the read strobe low only during its strobe cycles. An external write drives `bus_we_l_n` low when `req_be[0]`=1 and `bus_we_h_n` low when `req_be[1]`=1, only during its strobe cycles. No write strobe falls for internal writes.
- R8: In bus modes (`proc_mode` other than 00), `e_rde_n` carries the active-low read strobe. For internal reads it stays high if `cfg_sig_off`=1 at acceptance, and goes low if `cfg_sig_off`=0.
- R9: In mode 00, `bus_pins_en` is 0 and `e_rde_n` carries a phase signal that inverts every clock cycle. If `cfg_sig_off`=1, the pin is forced to 0 instead. In other modes `bus_pins_en` is 1.
- R10: An access is blocked if it is non-internal in mode 00, or if its address is at or above 0x100000 in a bus mode. A blocked access drives no strobe and completes in the cycle after acceptance with `acc_fault`=1.
- R11: `acc_done` pulses for one cycle directly after the last strobe cycle, or directly after acceptance for a blocked access. `acc_fault` is 1 only together with `acc_done`.
- R12: `bus_addr` shows the accepted address from the cycle after acceptance until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW (24) | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables: bit 0 low byte, bit 1 high byte |
| cfg_wait_n | input | 1 | 0 = stretch external accesses, 1 = no wait |
| cfg_wait_sel | input | 1 | Stretch amount: 1 = 1.5x, 0 = 2x |
| cfg_sig_off | input | 1 | Output-disable select for the shared pin |
| proc_mode | input | 2 | 00 single-chip, 01 memory expansion, 10/11 microprocessor |
| bus_addr | output | AW (24) | Latched address of the current access |
| bus_ale | output | 1 | Address latch enable |
| e_rde_n | output | 1 | Shared pin: phase signal or active-low read enable |
| bus_we_l_n | output | 1 | Active-low low-byte write strobe |
| bus_we_h_n | output | 1 | Active-low high-byte write strobe |
| acc_done | output | 1 | Completion pulse to the core |
| acc_fault | output | 1 | Completion was for a blocked access |
| bus_pins_en | output | 1 | Port pins serve the external bus |

## Verification
The bench builds the block with its default parameters. These are a 24-bit address, an internal low range ending at 0x1000, an expansion-mode ROM window from 0x8000 to 0x1FFFF, and a bank limit of 0x100000. With these values every region boundary can be hit with ordinary address values, and every strobe length of 2, 3 and 4 half-phases completes in a handful of cycles. Because of that, random accesses across all four modes and every wait setting can be compared cycle by cycle against a bench model. The edges 0xFFF/0x1000, 0x7FFF/0x8000, 0x1FFFF/0x20000 and 0xFFFFF/0x100000 are driven directly.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  // half-phase counts of the strobe for each access length
  localparam int unsigned HP_NOWAIT  = 2;
  localparam int unsigned HP_ONEHALF = 3;
  localparam int unsigned HP_DOUBLE  = 4;
  localparam int unsigned LEN_W      = $clog2(HP_DOUBLE + 1);

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_MPROC  = 2'b10,
    MODE_MPROC2 = 2'b11
  } proc_mode_e;

  typedef enum logic [1:0] {
    ACC_INT   = 2'd0,
    ACC_EXT   = 2'd1,
    ACC_BLOCK = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  function automatic logic [LEN_W-1:0] stretch_len(input logic wait_n, input logic wait_sel);
    if (wait_n)        return LEN_W'(HP_NOWAIT);
    else if (wait_sel) return LEN_W'(HP_ONEHALF);
    else               return LEN_W'(HP_DOUBLE);
  endfunction
endpackage

// File: rtl/ebw_region_dec.sv
module ebw_region_dec
  import ebw_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter logic [AW-1:0] INT_LOW_END = 24'h00_1000,
  parameter logic [AW-1:0] ROM_BASE    = 24'h00_8000,
  parameter logic [AW-1:0] ROM_END     = 24'h01_FFFF,
  parameter logic [AW-1:0] BANK_LIMIT  = 24'h10_0000
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  output acc_kind_e     kind
);
  logic in_low, in_rom, above_limit;

  always_comb begin
    in_low      = (addr < INT_LOW_END);
    in_rom      = (proc_mode_e'(mode) == MODE_EXPAND) && (addr >= ROM_BASE) && (addr <= ROM_END);
    above_limit = (addr >= BANK_LIMIT);
    if (in_low || in_rom)
      kind = ACC_INT;
    else if (proc_mode_e'(mode) == MODE_SINGLE || above_limit)
      kind = ACC_BLOCK;
    else
      kind = ACC_EXT;
  end
endmodule

// File: rtl/ebw_phase_seq.sv
module ebw_phase_seq
  import ebw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  acc_kind_e        kind,
  input  logic [LEN_W-1:0] ext_len,
  output logic             idle,
  output logic             addr_phase,
  output logic             strobe_phase,
  output logic             fin,
  output logic             fin_fault
);
  seq_state_e       state_q;
  logic [LEN_W-1:0] left_q;
  logic             fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          fault_q <= (kind == ACC_BLOCK);
          unique case (kind)
            ACC_EXT: begin
              state_q <= ST_ADDR;
              left_q  <= ext_len;
            end
            ACC_INT: begin
              state_q <= ST_STRB;
              left_q  <= LEN_W'(HP_NOWAIT);
            end
            default: begin
              state_q <= ST_FIN;
              left_q  <= '0;
            end
          endcase
        end
        ST_ADDR: state_q <= ST_STRB;
        ST_STRB: begin
          if (left_q == LEN_W'(1)) state_q <= ST_FIN;
          left_q <= left_q - LEN_W'(1);
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          fault_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle         = (state_q == ST_IDLE);
  assign addr_phase   = (state_q == ST_ADDR);
  assign strobe_phase = (state_q == ST_STRB);
  assign fin          = (state_q == ST_FIN);
  assign fin_fault    = fin && fault_q;
endmodule

// File: rtl/ebw_pin_sel.sv
module ebw_pin_sel
  import ebw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sig_off,
  input  logic       rd_n,
  output logic       shared_pin,
  output logic       bus_pins
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  always_comb begin
    bus_pins = (proc_mode_e'(mode) != MODE_SINGLE);
    if (bus_pins) shared_pin = rd_n;
    else          shared_pin = sig_off ? 1'b0 : phase_q;
  end
endmodule

// File: rtl/ebw_ctrl.sv
module ebw_ctrl
  import ebw_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter logic [AW-1:0] INT_LOW_END = 24'h00_1000,
  parameter logic [AW-1:0] ROM_BASE    = 24'h00_8000,
  parameter logic [AW-1:0] ROM_END     = 24'h01_FFFF,
  parameter logic [AW-1:0] BANK_LIMIT  = 24'h10_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_be,
  input  logic          cfg_wait_n,
  input  logic          cfg_wait_sel,
  input  logic          cfg_sig_off,
  input  logic [1:0]    proc_mode,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          e_rde_n,
  output logic          bus_we_l_n,
  output logic          bus_we_h_n,
  output logic          acc_done,
  output logic          acc_fault,
  output logic          bus_pins_en
);
  acc_kind_e        kind_d, kind_q;
  logic             take;
  logic             idle, addr_ph, strb_ph, fin, fin_fault;
  logic             wr_q, soff_q;
  logic [1:0]       be_q;
  logic [AW-1:0]    addr_q;
  logic             rd_n;

  ebw_region_dec #(
    .AW(AW), .INT_LOW_END(INT_LOW_END), .ROM_BASE(ROM_BASE),
    .ROM_END(ROM_END), .BANK_LIMIT(BANK_LIMIT)
  ) u_dec (
    .addr (req_addr),
    .mode (proc_mode),
    .kind (kind_d)
  );

  assign take = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_INT;
      wr_q   <= 1'b0;
      soff_q <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
    end else if (take) begin
      kind_q <= kind_d;
      wr_q   <= req_write;
      soff_q <= cfg_sig_off;
      be_q   <= req_be;
      addr_q <= req_addr;
    end
  end

  ebw_phase_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (take),
    .kind         (kind_d),
    .ext_len      (stretch_len(cfg_wait_n, cfg_wait_sel)),
    .idle         (idle),
    .addr_phase   (addr_ph),
    .strobe_phase (strb_ph),
    .fin          (fin),
    .fin_fault    (fin_fault)
  );

  always_comb begin
    rd_n       = ~(strb_ph && !wr_q && (kind_q == ACC_EXT || !soff_q));
    bus_we_l_n = ~(strb_ph && wr_q && (kind_q == ACC_EXT) && be_q[0]);
    bus_we_h_n = ~(strb_ph && wr_q && (kind_q == ACC_EXT) && be_q[1]);
  end

  ebw_pin_sel u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (proc_mode),
    .sig_off    (cfg_sig_off),
    .rd_n       (rd_n),
    .shared_pin (e_rde_n),
    .bus_pins   (bus_pins_en)
  );

  assign req_ready = idle;
  assign bus_ale   = addr_ph;
  assign bus_addr  = addr_q;
  assign acc_done  = fin;
  assign acc_fault = fin_fault;
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic bus_ale,
  input logic bus_we_l_n,
  input logic bus_we_h_n,
  input logic acc_done,
  input logic acc_fault
);
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale || !bus_we_l_n || !bus_we_h_n) |-> !req_ready);

  a_r5_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  a_r5_ale_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_we_l_n && bus_we_h_n));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  a_r11_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> acc_done);

  a_r11_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> req_ready);
endmodule

bind ebw_ctrl ebw_checker u_ebw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .bus_ale    (bus_ale),
  .bus_we_l_n (bus_we_l_n),
  .bus_we_h_n (bus_we_h_n),
  .acc_done   (acc_done),
  .acc_fault  (acc_fault)
);

// File: tb/ebw_ctrl_test.sv
`timescale 1ns/1ps
module ebw_ctrl_test;
  localparam int AW = 24;
  localparam int K_INT = 0, K_EXT = 1, K_BLK = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [1:0]    req_be = 2'b00;
  logic          cfg_wait_n = 1'b0, cfg_wait_sel = 1'b0, cfg_sig_off = 1'b0;
  logic [1:0]    proc_mode = 2'b01;
  logic [AW-1:0] bus_addr;
  logic          bus_ale, e_rde_n, bus_we_l_n, bus_we_h_n;
  logic          acc_done, acc_fault, bus_pins_en;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  ebw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .cfg_wait_n(cfg_wait_n), .cfg_wait_sel(cfg_wait_sel), .cfg_sig_off(cfg_sig_off),
    .proc_mode(proc_mode), .bus_addr(bus_addr), .bus_ale(bus_ale), .e_rde_n(e_rde_n),
    .bus_we_l_n(bus_we_l_n), .bus_we_h_n(bus_we_h_n), .acc_done(acc_done),
    .acc_fault(acc_fault), .bus_pins_en(bus_pins_en)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int kind_of(input logic [AW-1:0] a, input logic [1:0] m);
    if (a < 24'h1000) return K_INT;
    if (m == 2'b01 && a >= 24'h8000 && a <= 24'h1FFFF) return K_INT;
    if (m == 2'b00) return K_BLK;
    if (a >= 24'h100000) return K_BLK;
    return K_EXT;
  endfunction

  function automatic int len_of(input logic wn, input logic ws);
    return wn ? 2 : (ws ? 3 : 4);
  endfunction

  // one access, compared cycle by cycle against the requirement model
  task automatic access(input logic [AW-1:0] a, input logic wr, input logic [1:0] be,
                        input logic [1:0] m, input logic wn, input logic ws, input logic so);
    int kd, ln, last, s0, s1;
    @(negedge clk);
    proc_mode = m; cfg_wait_n = wn; cfg_wait_sel = ws; cfg_sig_off = so;
    req_addr = a; req_write = wr; req_be = be; req_valid = 1'b1;
    check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    kd = kind_of(a, m);
    ln = len_of(wn, ws);
    last = (kd == K_EXT) ? 2 + ln : (kd == K_INT) ? 3 : 1;
    s0 = (kd == K_EXT) ? 2 : 1;
    s1 = (kd == K_EXT) ? 1 + ln : 2;
    for (int k = 1; k <= last; k++) begin
      bit strb, ale_e, rd_e, wl_e, wh_e;
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        req_addr  = ~a;
      end
      strb  = (kd != K_BLK) && k >= s0 && k <= s1;
      ale_e = (kd == K_EXT) && k == 1;
      rd_e  = !(strb && !wr && (kd == K_EXT || !so));
      wl_e  = !(strb && wr && kd == K_EXT && be[0]);
      wh_e  = !(strb && wr && kd == K_EXT && be[1]);
      check(req_ready == 1'b0, "R1 busy", req_ready, 0);
      check(bus_ale == ale_e, "R5 ale", bus_ale, ale_e);
      check(bus_we_l_n == wl_e, "R7 we_l", bus_we_l_n, wl_e);
      check(bus_we_h_n == wh_e, "R7 we_h", bus_we_h_n, wh_e);
      if (m != 2'b00) begin
        if (kd == K_EXT && !wr)
          check(e_rde_n == rd_e, (ln == 2) ? "R2 strobe" : (ln == 3) ? "R3 strobe" : "R4 strobe",
                e_rde_n, rd_e);
        else if (kd == K_INT)
          check(e_rde_n == rd_e, "R8/R6 internal rde", e_rde_n, rd_e);
        else
          check(e_rde_n == rd_e, "R10 no strobe", e_rde_n, rd_e);
      end
      check(acc_done == (k == last), "R11 done", acc_done, k == last);
      check(acc_fault == (k == last && kd == K_BLK), "R10 fault", acc_fault, k == last && kd == K_BLK);
      check(bus_addr == a, "R12 bus_addr", bus_addr, a);
    end
  endtask

  function automatic logic [AW-1:0] rand_addr();
    case ($urandom % 5)
      0: return AW'($urandom % 32'h1000);
      1: return AW'(32'h8000 + ($urandom % 32'h18000));
      2: return AW'(32'h1000 + ($urandom % 32'h7000));
      3: return AW'(32'h20000 + ($urandom % 32'hE0000));
      default: return AW'(32'h100000 + ($urandom % 32'hF00000));
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    check(bus_ale == 1'b0, "R5 reset ale", bus_ale, 0);
    check(bus_we_l_n && bus_we_h_n, "R7 reset we", {bus_we_h_n, bus_we_l_n}, 3);
    check(acc_done == 1'b0, "R11 reset done", acc_done, 0);
    check(e_rde_n == 1'b1, "R8 reset rde", e_rde_n, 1);
    check(bus_pins_en == 1'b1, "R9 pins in expansion", bus_pins_en, 1);

    // directed: three stretch lengths, reads and writes
    access(24'h020000, 1'b0, 2'b11, 2'b01, 1'b1, 1'b0, 1'b0); // R2
    access(24'h020002, 1'b0, 2'b11, 2'b01, 1'b0, 1'b1, 1'b0); // R3
    access(24'h020004, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0); // R4
    access(24'h030000, 1'b1, 2'b01, 2'b10, 1'b0, 1'b1, 1'b0); // R7 low byte
    access(24'h030001, 1'b1, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0); // R7 high byte
    // R6: internal ignores wait; boundaries
    access(24'h000FFF, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0);
    access(24'h001000, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0);
    access(24'h007FFF, 1'b0, 2'b11, 2'b01, 1'b0, 1'b1, 1'b0);
    access(24'h008000, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1); // R8 suppressed
    access(24'h01FFFF, 1'b1, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0); // R7 internal write
    access(24'h020000, 1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0);
    access(24'h008000, 1'b0, 2'b11, 2'b10, 1'b1, 1'b0, 1'b1); // ROM external in mode 10
    // R10 boundaries
    access(24'h0FFFFF, 1'b0, 2'b11, 2'b01, 1'b1, 1'b0, 1'b0);
    access(24'h100000, 1'b0, 2'b11, 2'b01, 1'b1, 1'b0, 1'b0);
    access(24'h020000, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);

    // R9 single-chip pin behaviour
    @(negedge clk);
    proc_mode = 2'b00; cfg_sig_off = 1'b0;
    @(negedge clk);
    check(bus_pins_en == 1'b0, "R9 pins single-chip", bus_pins_en, 0);
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = e_rde_n;
      @(negedge clk);
      check(e_rde_n == !prev, "R9 phase toggles", e_rde_n, !prev);
    end
    cfg_sig_off = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(e_rde_n == 1'b0, "R9 forced low", e_rde_n, 0);
    end

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [1:0] be;
      be = 2'($urandom % 3) + 2'd1;
      access(rand_addr(), 1'($urandom), be, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    check(req_ready == 1'b1, "R1 final idle", req_ready, 1);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule